// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Lock and Default Parking

This block decides which of sixteen masters owns a shared system bus. Each master raises a request line and may also raise a lock line. The arbiter answers with a registered one-hot grant vector and a registered 4-bit owner index. The owner index serves as the select value for the bus-signal multiplexer that sits outside the block.

Ownership rotates among the requesting masters, so none of them can be starved. A master that owns the bus and holds its lock line high keeps the bus for as long as that line stays high. When nobody requests, the bus parks on master 0. Once a requesting master has been granted, the grant is frozen until the transfer reports completion on a single done input. Arbitration then resumes at that clock edge.

Top module: `rr_lock_arbiter`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), and in the cycle after it is released, the grant vector is 16'h0001 and the owner index is 0.
- R2: At all times, exactly one bit of the grant vector is set, and that bit's position equals the owner index. Grant bit i belongs to master i.
- R3: At an enabled edge where the owner is not locked and at least one request is high, the grant goes to the first requesting master found by searching upward and wrapping past 15. The search begins at the master just after the last master granted by a request. That master then becomes the new last-granted master.
- R4: At an enabled edge with no lock hold and no request, the bus parks on master 0. The last-granted master is left unchanged, so parking does not alter the rotation order.
- R5: An edge is enabled when the bus is parked or the done input is high. After a request-driven grant, grant and owner stay constant until the first edge at which done is sampled high, even if the owner's request drops.
- R6: At an enabled edge where the lock bit of the current owner is high, the owner keeps the bus and the rotation order is not advanced. This holds even if that owner's request is low.
- R7: Lock bits of masters that do not own the bus have no effect on the choice of winner.
- R8: Once the locked owner drops both its request and its lock, the next enabled edge arbitrates by the rotation rule of R3.
- R9: After reset, master 1 has the highest priority. With all masters requesting at the first enabled edge, master 1 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Bus request, bit i from master i |
| lock_i | input | 16 | Lock indication, bit i from master i |
| xfer_done_i | input | 1 | Completion pulse of the current transfer |
| grant_o | output | 16 | Registered one-hot grant |
| owner_o | output | 4 | Registered index of the granted master |

## Verification
The hardest state to reach from the ports is a park that happens while the rotation pointer is away from master 0. That is the only situation in which a design that wrongly moves the pointer on a park behaves differently from a correct one. The stimulus first grants master 3 and then completes a transfer with no requests. This parks the bus while the pointer still marks master 3. It then raises requests from masters 0 and 2 without a done pulse, and master 0 must win. A second hard case is a lock held by a master that does not own the bus. The stimulus sets that master's request together with its lock and checks that rotation reaches it as usual rather than freezing on the owner.

// File: rtl/rr_lock_arbiter.sv
module rr_lock_arbiter #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  lock_i,
  input  logic          xfer_done_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] owner_o
);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick;
  logic          busy_q;
  logic          arb_en;
  logic          hold;
  logic          any_req;

  assign arb_en  = !busy_q || xfer_done_i;
  assign hold    = lock_i[owner_o];
  assign any_req = |req_i;

  always_comb begin
    pick = '0;
    for (int k = N; k >= 1; k--) begin
      if (req_i[(int'(ptr_q) + k) % N]) pick = IW'((int'(ptr_q) + k) % N);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o <= N'(1);
      owner_o <= '0;
      ptr_q   <= '0;
      busy_q  <= 1'b0;
    end else if (arb_en) begin
      if (hold) begin
        busy_q <= 1'b1;
      end else if (any_req) begin
        grant_o <= N'(1) << pick;
        owner_o <= pick;
        ptr_q   <= pick;
        busy_q  <= 1'b1;
      end else begin
        grant_o <= N'(1);
        owner_o <= '0;
        busy_q  <= 1'b0;
      end
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == 1);

  p_owner_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[owner_o]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !xfer_done_i |=> $stable(grant_o) && $stable(owner_o));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en && lock_i[owner_o] |=> $stable(owner_o));

  p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en && !hold && !any_req |=> owner_o == '0);

  p_winner_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en && !hold && any_req |=> (grant_o & $past(req_i)) != '0);

endmodule

// File: tb/rr_lock_arbiter_test.sv
`timescale 1ns/1ps
module rr_lock_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic [15:0] lock = '0;
  logic        done = 1'b0;
  logic [15:0] grant;
  logic [3:0]  owner;
  int          n_tests = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  rr_lock_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock),
    .xfer_done_i(done), .grant_o(grant), .owner_o(owner)
  );

  // {req, lock, done, expected owner}
  localparam int NV = 19;
  localparam logic [36:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 4'd0},
    {16'h0003, 16'h0000, 1'b0, 4'd1},
    {16'h0003, 16'h0000, 1'b0, 4'd1},
    {16'h0003, 16'h0000, 1'b1, 4'd0},
    {16'h8001, 16'h0000, 1'b1, 4'd15},
    {16'h8001, 16'h0000, 1'b1, 4'd0},
    {16'h0010, 16'h0000, 1'b0, 4'd0},
    {16'h0010, 16'h0000, 1'b1, 4'd4},
    {16'h0010, 16'h0010, 1'b1, 4'd4},
    {16'h0030, 16'h0010, 1'b1, 4'd4},
    {16'h0020, 16'h0010, 1'b1, 4'd4},
    {16'h0020, 16'h0000, 1'b1, 4'd5},
    {16'h0060, 16'h0040, 1'b1, 4'd6},
    {16'h0041, 16'h0001, 1'b1, 4'd0},
    {16'h0008, 16'h0000, 1'b1, 4'd3},
    {16'h0000, 16'h0000, 1'b1, 4'd0},
    {16'h0005, 16'h0000, 1'b0, 4'd0},
    {16'h0005, 16'h0000, 1'b0, 4'd0},
    {16'hFFFF, 16'h0000, 1'b1, 4'd1}
  };
  localparam string TAG [NV] = '{
    "R4", "R9", "R5", "R3", "R3", "R3", "R5", "R3", "R6", "R6",
    "R6", "R8", "R7", "R7", "R3", "R4", "R4", "R5", "R3"
  };

  task automatic check(input string tag, input logic [3:0] exp);
    n_tests++;
    if (owner !== exp || grant !== (16'h1 << exp)) begin
      n_fail++;
      $display("FAIL %s: owner=%0d grant=%h expected owner=%0d grant=%h",
               tag, owner, grant, exp, 16'h1 << exp);
    end
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #12;
    check("R1", 4'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      req  = VEC[i][36:21];
      lock = VEC[i][20:5];
      done = VEC[i][4];
      @(posedge clk);
      @(negedge clk);
      check(TAG[i], VEC[i][3:0]);
      check("R2", VEC[i][3:0]);
    end
    // reset in the middle of a granted transfer
    req = 16'h0400; done = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3", 4'd10);
    rst_n = 1'b0; done = 1'b0;
    #1;
    check("R1", 4'd0);
    @(negedge clk); rst_n = 1'b1; req = 16'hFFFF; lock = 16'hFFFF;
    // lock of master 0 holds the reset owner
    @(posedge clk); @(negedge clk);
    check("R6", 4'd0);
    lock = 16'hFFFE; done = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9", 4'd1);
    req = '0; lock = '0; done = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5", 4'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule